// File: doc/BRIEF.md
# Full-Duplex SPI Master with Byte FIFOs

This block is a memory-mapped SPI master. Software fills a 16-byte transmit queue through a single data address. It then issues one start write that carries two counts. The first is how many bytes come from the queue. The second is how many bytes the whole transfer lasts, up to 255. The engine drives the serial clock, MOSI and chip select. It samples MISO and stores every received byte in a 16-byte receive queue, which software drains through the same data address. When the queue's bytes run out before the transfer length is reached, the engine sends zero bytes.

Clock polarity, sampling phase, bit order and chip-select polarity are set in a configuration word. That word also holds a 16-bit divider select. A status word reports the state of both queues, a sticky finish flag and the programmed lengths. If the transmit queue runs dry while queue bytes are still owed, or the receive queue is full, the engine holds the clock idle with chip select asserted until software catches up. Nothing is dropped or repeated. A registered, level-type interrupt combines three enabled conditions.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the status word (address 1) reads 0x0000_0014: bit 2 (TX empty) and bit 4 (RX empty) are set, and all counts, lengths and the finish bit 6 are zero. Chip select is inactive, SCLK sits at the configured idle level, and the interrupt is low.
- R2: Writing address 0 pushes bits 7:0 into the TX queue. Reading address 0 pops the RX queue and returns the byte in bits 7:0 one cycle later. Reading an empty RX queue returns 0. Status bits 11:8 and 15:12 give the low four bits of the TX and RX fill counts, and bit 5 flags a full RX queue.
- R3: A status write with bit 0 set, bit 1 clear and a nonzero total length in bits 31:24 starts a transfer, with the queue byte count taken from bits 23:16. Both lengths read back in the same fields. Such a write is ignored when the total is zero or a transfer is already running.
- R4: Byte k of a transfer (k counting from 0) is taken from the TX queue while k is below the queue byte count, and is 0x00 otherwise. Every received byte is written into the RX queue in order.
- R5: SCLK idles at configuration bit 0. Each half period lasts N+1 system clocks, where N is configuration bits 31:16.
- R6: When configuration bit 1 is set, data is driven on the leading SCLK edge and sampled on the trailing edge. When it is clear (software sets bit 2 instead), the first bit is driven before the leading edge, sampling happens on leading edges and driving on trailing edges.
- R7: Configuration bit 4 set shifts each byte least significant bit first; clear shifts most significant bit first. Both directions use the same order.
- R8: Chip select is active high when configuration bit 5 is set, otherwise active low. It asserts N+2 system clocks before the first SCLK edge. It releases in the same cycle that the last received byte enters the RX queue, which is also the cycle the finish flag sets.
- R9: If the TX queue is empty while queue bytes are still owed, SCLK stops at its idle level with chip select held. The transfer resumes once bytes are pushed.
- R10: If the RX queue is full at a byte boundary, SCLK stops with chip select held. No received byte is lost, and the transfer resumes once software pops a byte.
- R11: Writing a 1 to status bit 6 clears the finish flag.
- R12: The interrupt output is registered. One cycle after its inputs, it equals (bit 11 AND TX empty) OR (bit 14 AND RX full) OR (bit 15 AND finish), where bits 11, 14 and 15 are configuration enables.
- R13: A status write with bit 1 set empties both queues, stops the engine, and clears the finish flag and both lengths. The configuration word is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 configuration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after the read strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip select, polarity set by configuration bit 5 |
| irq | output | 1 | Registered level interrupt |

## Verification
Read data is due one cycle after the read strobe. A status or configuration write takes effect at the clock edge that accepts it, and the interrupt follows its flags one cycle later. The first SCLK toggle comes N+2 clocks after chip select asserts, and later toggles within a byte come every N+1 clocks. The finish flag and chip-select release land together at the final RX push. The bench drives the bus on falling edges and samples outputs at the next falling edge, so each single-cycle result is read exactly where it is due. A falling-edge monitor counts the clocks between chip select and SCLK changes and compares them with the arithmetic above. It also rebuilds the bytes seen on MOSI from the configured phase and order. End of transfer is found by polling the finish flag rather than assuming a fixed count.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_LOAD  = 2'd1,
    ENG_SHIFT = 2'd2,
    ENG_PUSH  = 2'd3
  } eng_state_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;

  // status word bit positions
  localparam int ST_GO   = 0;
  localparam int ST_SRST = 1;
  localparam int ST_FIN  = 6;

  // configuration word bit positions
  localparam int CF_CPOL   = 0;
  localparam int CF_RDPH   = 1;
  localparam int CF_LSB    = 4;
  localparam int CF_CSHI   = 5;
  localparam int CF_IE_TXE = 11;
  localparam int CF_IE_RXF = 14;
  localparam int CF_IE_FIN = 15;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       pop,
  output logic [WIDTH-1:0]           rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];
  assign count   = cnt;

  // storage kept free of reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R2

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] total_len,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic             cs_high,
  input  logic [7:0]       tx_byte,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             done,
  output logic             active,
  output logic             sclk,
  output logic             mosi,
  output logic             cs
);
  eng_state_t       state;
  logic [DIV_W-1:0] hcnt;
  logic [3:0]       ecnt;
  logic             ph, act, mosi_q;
  logic [7:0]       tx_sh, rx_sh;
  logic [LEN_W-1:0] byte_idx;

  logic       need_tx, can_go, last_byte, at_edge, leading, smp_now, drv_now;
  logic [7:0] load_val;

  function automatic logic head_bit(input logic [7:0] b, input logic lsb);
    return lsb ? b[0] : b[7];
  endfunction

  function automatic logic [7:0] advance(input logic [7:0] b, input logic lsb);
    return lsb ? {1'b0, b[7:1]} : {b[6:0], 1'b0};
  endfunction

  assign need_tx   = (byte_idx < tx_len);
  assign can_go    = !rx_full && !(need_tx && tx_empty);
  assign load_val  = need_tx ? tx_byte : 8'h00;
  assign last_byte = (({1'b0, byte_idx} + 1'b1) == {1'b0, total_len});
  assign at_edge   = (state == ENG_SHIFT) && (hcnt == div_sel);
  assign leading   = !ecnt[0];
  assign smp_now   = cpha ? !leading : leading;
  assign drv_now   = cpha ? leading : !leading;

  assign tx_pop  = (state == ENG_LOAD) && can_go && need_tx;
  assign rx_push = (state == ENG_PUSH);
  assign rx_byte = rx_sh;
  assign done    = (state == ENG_PUSH) && last_byte;
  assign active  = act;
  assign sclk    = ph ^ cpol;
  assign mosi    = mosi_q;
  assign cs      = act ? cs_high : !cs_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      hcnt     <= '0;
      ecnt     <= '0;
      ph       <= 1'b0;
      act      <= 1'b0;
      mosi_q   <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      byte_idx <= '0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (start) begin
            state    <= ENG_LOAD;
            act      <= 1'b1;
            byte_idx <= '0;
          end
        end
        ENG_LOAD: begin
          if (can_go) begin
            hcnt  <= '0;
            ecnt  <= '0;
            state <= ENG_SHIFT;
            if (!cpha) begin
              mosi_q <= head_bit(load_val, lsb_first);
              tx_sh  <= advance(load_val, lsb_first);
            end else begin
              tx_sh  <= load_val;
            end
          end
        end
        ENG_SHIFT: begin
          if (hcnt == div_sel) begin
            hcnt <= '0;
            ph   <= !ph;
            ecnt <= ecnt + 1'b1;
            if (smp_now)
              rx_sh <= lsb_first ? {miso, rx_sh[7:1]} : {rx_sh[6:0], miso};
            if (drv_now) begin
              mosi_q <= head_bit(tx_sh, lsb_first);
              tx_sh  <= advance(tx_sh, lsb_first);
            end
            if (ecnt == 4'd15) state <= ENG_PUSH;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ENG_PUSH: begin
          byte_idx <= byte_idx + 1'b1;
          if (last_byte) begin
            state <= ENG_IDLE;
            act   <= 1'b0;
          end else begin
            state <= ENG_LOAD;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  AST_RX_ROOM: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !rx_full); // R10

  AST_TX_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> !tx_empty); // R9

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_LOAD || !act) |-> (sclk == cpol)); // R5

  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(act) |-> ($past(rx_push) || $past(rst))); // R8

  AST_EDGE_IN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    $changed(ph) |-> ($past(state) == ENG_SHIFT || $past(rst))); // R9

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 8,
  parameter int DIV_W      = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs,
  output logic        irq
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic [31:0]      cfg_q, rdata_q;
  logic [LEN_W-1:0] tx_len_q, tot_len_q;
  logic             fin_q, irq_q;

  logic wr_data, wr_stat, wr_cfg, rd_data, srst, core_rst, start;
  logic eng_active, eng_done, tx_pop, rx_push;
  logic [7:0] tx_head, rx_head, rx_in;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [31:0] stat_word;

  assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
  assign wr_cfg   = bus_wr && (bus_addr == ADDR_CFG);
  assign rd_data  = bus_rd && (bus_addr == ADDR_DATA);
  assign srst     = wr_stat && bus_wdata[ST_SRST];
  assign core_rst = rst || srst;
  assign start    = wr_stat && bus_wdata[ST_GO] && !bus_wdata[ST_SRST]
                    && (bus_wdata[31:24] != 8'd0) && !eng_active;

  spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst(core_rst), .push(wr_data), .wdata(bus_wdata[7:0]),
    .pop(tx_pop), .rdata(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(core_rst), .push(rx_push), .wdata(rx_in),
    .pop(rd_data), .rdata(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  spi_shift_engine #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_engine (
    .clk(clk), .rst(core_rst), .start(start),
    .tx_len(tx_len_q), .total_len(tot_len_q),
    .div_sel(DIV_W'(cfg_q[31:16])),
    .cpol(cfg_q[CF_CPOL]), .cpha(cfg_q[CF_RDPH]),
    .lsb_first(cfg_q[CF_LSB]), .cs_high(cfg_q[CF_CSHI]),
    .tx_byte(tx_head), .tx_empty(tx_empty), .rx_full(rx_full), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_in), .done(eng_done),
    .active(eng_active), .sclk(sclk), .mosi(mosi), .cs(cs)
  );

  assign stat_word = {8'(tot_len_q), 8'(tx_len_q), 4'(rx_cnt), 4'(tx_cnt),
                      1'b0, fin_q, rx_full, rx_empty, tx_full & 1'b0, tx_empty, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (wr_cfg) cfg_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      tx_len_q  <= '0;
      tot_len_q <= '0;
      fin_q     <= 1'b0;
    end else begin
      if (start) begin
        tx_len_q  <= LEN_W'(bus_wdata[23:16]);
        tot_len_q <= LEN_W'(bus_wdata[31:24]);
      end
      if (eng_done)                          fin_q <= 1'b1;
      else if (wr_stat && bus_wdata[ST_FIN]) fin_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) begin
        case (bus_addr)
          ADDR_DATA: rdata_q <= rx_empty ? 32'd0 : {24'd0, rx_head};
          ADDR_STAT: rdata_q <= stat_word;
          ADDR_CFG:  rdata_q <= cfg_q;
          default:   rdata_q <= 32'd0;
        endcase
      end
      irq_q <= (cfg_q[CF_IE_TXE] && tx_empty) || (cfg_q[CF_IE_RXF] && rx_full)
               || (cfg_q[CF_IE_FIN] && fin_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  AST_FIN_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && bus_wdata[ST_FIN] && !eng_done) |=> !fin_q); // R11

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (eng_active && wr_stat && bus_wdata[ST_GO] && !bus_wdata[ST_SRST])
      |=> $stable(tot_len_q) && $stable(tx_len_q)); // R3

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q[CF_IE_TXE] && !cfg_q[CF_IE_RXF] && !cfg_q[CF_IE_FIN]) |=> !irq); // R12

  AST_FIN_WITH_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(fin_q) |-> !eng_active); // R8

endmodule

// File: tb/test_spi_fifo_master.sv
`timescale 1ns/1ps
module test_spi_fifo_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso, cs, irq;

  always #2 clk = ~clk;
  assign miso = ~mosi;

  spi_fifo_master i_spi_fifo_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs(cs), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_cfg(input bit cpol, input bit cpha, input bit lsb,
                                         input bit csh, input int n, input logic [2:0] ie);
    return {n[15:0], ie[2], ie[1], 2'b00, ie[0], 4'b0000, 1'b1, csh, lsb, 1'b0,
            ~cpha, cpha, cpol};
  endfunction

  // MOSI monitor: rebuilds bytes from the configured phase and order, checks edge spacing
  bit mon_cpol, mon_cpha, mon_lsb, mon_csh;
  int mon_n = 0;
  logic [7:0] cap [0:31];
  int ncap = 0, bitc = 0, tog = 0, since = 0;
  logic [7:0] mbyte = 8'd0;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (rst || cs !== mon_csh) begin
      bitc = 0; tog = 0; since = 0; prev_sclk = sclk;
    end else begin
      since++;
      if (sclk !== prev_sclk) begin
        if (tog == 0) chk("R8 cs lead to first edge", since, mon_n + 3);
        else if (tog % 16 != 0) chk("R5 half period", since, mon_n + 1);
        if (mon_cpha ? (sclk === mon_cpol) : (sclk !== mon_cpol)) begin
          mbyte = mon_lsb ? {mosi, mbyte[7:1]} : {mbyte[6:0], mosi};
          bitc++;
          if (bitc == 8) begin
            if (ncap < 32) cap[ncap] = mbyte;
            ncap++; bitc = 0;
          end
        end
        since = 0; tog++;
        prev_sclk = sclk;
      end
    end
  end

  task automatic set_mon(input bit cpol, input bit cpha, input bit lsb, input bit csh, input int n);
    mon_cpol = cpol; mon_cpha = cpha; mon_lsb = lsb; mon_csh = csh; mon_n = n; ncap = 0;
  endtask

  task automatic wait_fin(input string tag);
    logic [31:0] s;
    int k;
    s = 32'd0;
    for (k = 0; k < 5000; k++) begin
      rd(2'd1, s);
      if (s[6]) break;
    end
    chk(tag, {31'd0, s[6]}, 32'd1);
  endtask

  logic [7:0] txb [0:31];

  task automatic run_xfer(input bit cpol, input bit cpha, input bit lsb, input bit csh,
                          input int n, input int ntx, input int ntot, input int seed);
    logic [31:0] d;
    wr(2'd2, mk_cfg(cpol, cpha, lsb, csh, n, 3'b100));
    set_mon(cpol, cpha, lsb, csh, n);
    chk("R8 cs idle level", {31'd0, cs}, {31'd0, ~csh});
    chk("R5 sclk idle level", {31'd0, sclk}, {31'd0, cpol});
    for (int k = 0; k < ntx; k++) begin
      txb[k] = 8'(seed * 37 + k * 11 + 5);
      wr(2'd0, {24'd0, txb[k]});
    end
    wr(2'd1, {8'(ntot), 8'(ntx), 15'd0, 1'b1});
    wait_fin("R8 finish flag");
    chk("R8 cs released", {31'd0, cs}, {31'd0, ~csh});
    chk("R12 finish irq", {31'd0, irq}, 32'd1);
    rd(2'd1, d);
    chk("R3 lengths readback", {16'd0, d[31:16]}, {16'd0, 8'(ntot), 8'(ntx)});
    chk("R2 rx count", {28'd0, d[15:12]}, 32'(ntot));
    for (int k = 0; k < ntot; k++) begin
      rd(2'd0, d);
      chk("R6 rx byte", d, {24'd0, (k < ntx) ? ~txb[k] : 8'hFF});
    end
    chk("R4 byte count on mosi", 32'(ncap), 32'(ntot));
    for (int k = 0; k < ntot && k < 32; k++)
      chk("R7 mosi byte", {24'd0, cap[k]}, {24'd0, (k < ntx) ? txb[k] : 8'h00});
    wr(2'd1, 32'h40);
    rd(2'd1, d);
    chk("R11 finish cleared", {31'd0, d[6]}, 32'd0);
    @(negedge clk);
    chk("R12 irq drops", {31'd0, irq}, 32'd0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int k;
    mon_csh = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    rd(2'd1, d);
    chk("R1 status after reset", d, 32'h0000_0014);
    chk("R1 cs inactive", {31'd0, cs}, 32'd1);
    chk("R1 sclk idle", {31'd0, sclk}, 32'd0);
    chk("R1 irq low", {31'd0, irq}, 32'd0);

    wr(2'd2, mk_cfg(0, 0, 0, 0, 0, 3'b001));
    chk("R12 irq one cycle later", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R12 tx empty irq", {31'd0, irq}, 32'd1);

    for (k = 0; k < 3; k++) wr(2'd0, 32'hA0 + k);
    rd(2'd1, d);
    chk("R2 tx count", {28'd0, d[11:8]}, 32'd3);
    chk("R2 tx empty clear", {31'd0, d[2]}, 32'd0);
    @(negedge clk);
    chk("R12 irq follows tx empty", {31'd0, irq}, 32'd0);
    rd(2'd0, d);
    chk("R2 empty rx read", d, 32'd0);

    wr(2'd1, 32'h2);
    rd(2'd1, d);
    chk("R13 soft reset status", d, 32'h0000_0014);
    rd(2'd2, d);
    chk("R13 config kept", d, mk_cfg(0, 0, 0, 0, 0, 3'b001));

    for (int i = 0; i < 16; i++)
      run_xfer(i[0], i[1], i[2], i[0] ^ i[2], i[3] ? 2 : 0, 3, 5, i);

    wr(2'd1, {8'd0, 8'd7, 15'd0, 1'b1});
    repeat (4) @(negedge clk);
    chk("R3 zero length ignored cs", {31'd0, cs}, 32'd1);
    rd(2'd1, d);
    chk("R3 zero length keeps lengths", {16'd0, d[31:16]}, 32'h0503);

    // TX stall
    wr(2'd2, mk_cfg(0, 0, 0, 0, 0, 3'b000));
    set_mon(0, 0, 0, 0, 0);
    txb[0] = 8'h3C; txb[1] = 8'hC3; txb[2] = 8'h5A; txb[3] = 8'h96;
    wr(2'd0, {24'd0, txb[0]});
    wr(2'd1, {8'd4, 8'd4, 15'd0, 1'b1});
    repeat (200) @(negedge clk);
    chk("R9 cs held in stall", {31'd0, cs}, 32'd0);
    chk("R9 sclk idle in stall", {31'd0, sclk}, 32'd0);
    chk("R9 one byte sent", 32'(ncap), 32'd1);
    wr(2'd1, {8'd9, 8'd9, 15'd0, 1'b1});
    rd(2'd1, d);
    chk("R3 busy start ignored", {16'd0, d[31:16]}, 32'h0404);
    chk("R9 no finish in stall", {31'd0, d[6]}, 32'd0);
    for (k = 1; k < 4; k++) wr(2'd0, {24'd0, txb[k]});
    wait_fin("R9 resumes to finish");
    for (k = 0; k < 4; k++) begin
      rd(2'd0, d);
      chk("R9 rx after stall", d, {24'd0, ~txb[k]});
      chk("R9 mosi after stall", {24'd0, cap[k]}, {24'd0, txb[k]});
    end
    wr(2'd1, 32'h40);

    // RX stall
    wr(2'd2, mk_cfg(1, 1, 1, 1, 0, 3'b010));
    set_mon(1, 1, 1, 1, 0);
    wr(2'd1, {8'd20, 8'd0, 15'd0, 1'b1});
    repeat (600) @(negedge clk);
    rd(2'd1, d);
    chk("R10 rx full flag", {31'd0, d[5]}, 32'd1);
    chk("R10 no finish while full", {31'd0, d[6]}, 32'd0);
    chk("R10 cs held", {31'd0, cs}, 32'd1);
    chk("R12 rx full irq", {31'd0, irq}, 32'd1);
    chk("R10 bytes sent before stall", 32'(ncap), 32'd16);
    for (k = 0; k < 16; k++) begin
      rd(2'd0, d);
      chk("R10 rx byte", d, 32'hFF);
    end
    wait_fin("R10 resumes to finish");
    for (k = 0; k < 4; k++) begin
      rd(2'd0, d);
      chk("R10 tail byte", d, 32'hFF);
    end
    chk("R4 zero fill count", 32'(ncap), 32'd20);
    for (k = 0; k < 20; k++)
      chk("R4 zero fill on mosi", {24'd0, cap[k]}, 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule